// File: doc/BRIEF.md
# Register-Controlled Prescaled PWM Generator

This block produces one pulse-width-modulated output from one free-running 8-bit counter. Software programs it through a plain address/data register port. A control register holds an enable bit and a 2-bit prescaler. A second register holds the duty count. The prescaler does not divide the clock. It selects how many low counter bits form one period, so a period lasts 128, 64, 32 or 16 input clocks for prescaler 0, 1, 2 or 3.

The output is high while the counter, masked to the active period bits, is below the effective duty value. There is no shadowing. A duty write changes the compare on the next cycle. A prescaler write changes the wrap length without clearing the counter. The duty and prescaler sit in separate registers, so no single write updates both. With prescaler 0 the duty is limited to 127, so the output is always low for at least one clock in every period. With prescaler 1 to 3 a duty at or above the period length holds the output high.

Top module: `duty_pwm_top`

## Requirements
- R1: After reset both registers read zero (disabled, prescaler 0, duty 0) and `pwm_o` is low.
- R2: Address 0 is the control register: bit 0 is enable, bits 2:1 are the prescaler, and bits 7:3 read as zero. Address 1 is the 8-bit duty register. `rdata` shows the addressed register one clock after `rd_en` and holds the last value written.
- R3: While enable is low, `pwm_o` is low and the counter is held at zero. In the first cycle after enable is written to 1, the counter is 0.
- R4: The period is 2^(7-p) clocks, where p is the prescaler. After the last step of a period, the phase returns to 0.
- R5: While enabled, `pwm_o` is high exactly when (counter mod 2^(7-p)) < the effective duty. For p = 1 to 3, a duty ≥ 2^(7-p) keeps the output high for the whole period.
- R6: With p = 0, the effective duty is min(duty, 127). The output is therefore low in the last step of every 128-clock period.
- R7: A duty write affects `pwm_o` from the cycle right after the write edge, in the middle of a period.
- R8: A prescaler write does not reset the counter. The counter keeps incrementing, and the new mask applies to its current value.
- R9: While enabled, the counter increases by one on each clock and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register select: 0 = control, 1 = duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pwm_o | output | 1 | PWM output |

## Verification
Every cycle, the assertions check the following:
- the counter is held at zero while disabled and increments by one while enabled;
- the phase returns to zero after a period wrap;
- the output is low at the last step of a prescaler-0 period;
- the output stays high when the duty covers a shorter period;
- the counter is not disturbed by a prescaler change;
- each register captures the written value.

Only the bench's scenarios can show the rest:
- the exact high-time per 128-clock window across prescalers and duty values;
- the cycle in which a mid-period duty write first changes the output;
- the output sequence after a prescaler switch in the middle of a period;
- the readback contents.

// File: rtl/duty_pwm_pkg.sv
package duty_pwm_pkg;
  localparam int CNT_W  = 8;
  localparam int PSC_W  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 1;

  // number of clocks in one period for prescaler psc: 2^(CNT_W-1-psc)
  function automatic logic [CNT_W-1:0] span_of(input logic [PSC_W-1:0] psc);
    return CNT_W'(1) << (CNT_W - 1 - int'(psc));
  endfunction

  // position of the counter inside the current period
  function automatic logic [CNT_W-1:0] phase_of(input logic [CNT_W-1:0] cnt,
                                                input logic [PSC_W-1:0] psc);
    return cnt & (span_of(psc) - CNT_W'(1));
  endfunction

  // duty after the limit that applies to the longest period
  function automatic logic [DATA_W-1:0] eff_duty_of(input logic [DATA_W-1:0] duty,
                                                    input logic [PSC_W-1:0] psc);
    logic [DATA_W-1:0] top_step;
    top_step = DATA_W'(span_of(psc)) - DATA_W'(1);
    if (psc == '0 && duty > top_step) return top_step;
    return duty;
  endfunction
endpackage

// File: rtl/duty_pwm_regs.sv
module duty_pwm_regs
  import duty_pwm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int PW = PSC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          en_o,
  output logic [PW-1:0] psc_o,
  output logic [DW-1:0] duty_o
);
  localparam int CTRL_W = PW + 1;
  localparam logic [AW-1:0] CTRL_ADDR = AW'(0);
  localparam logic [AW-1:0] DUTY_ADDR = AW'(1);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     duty_q;
  logic              ctrl_wr;
  logic              duty_wr;

  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);
  assign duty_wr = wr_en && (addr == DUTY_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
      if (duty_wr) duty_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == CTRL_ADDR)      rdata <= DW'(ctrl_q);
      else if (addr == DUTY_ADDR) rdata <= duty_q;
      else                        rdata <= '0;
    end
  end

  assign en_o   = ctrl_q[0];
  assign psc_o  = ctrl_q[CTRL_W-1:1];
  assign duty_o = duty_q;

  assert_ctrl_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> ctrl_q == $past(wdata[CTRL_W-1:0]));
  assert_duty_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    duty_wr |=> duty_q == $past(wdata));
endmodule

// File: rtl/duty_pwm_cnt.sv
module duty_pwm_cnt
  import duty_pwm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_o == '0);
  assert_step_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> cnt_o == CW'($past(cnt_o) + CW'(1)));
endmodule

// File: rtl/duty_pwm_cmp.sv
module duty_pwm_cmp
  import duty_pwm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PSC_W,
  parameter int DW = DATA_W
) (
  input  logic          en_i,
  input  logic [PW-1:0] psc_i,
  input  logic [DW-1:0] duty_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] phase_o,
  output logic          wrap_o,
  output logic          pwm_o
);
  logic [CW-1:0] span;
  logic [DW-1:0] eff_duty;

  always_comb begin
    span     = span_of(psc_i);
    phase_o  = phase_of(cnt_i, psc_i);
    eff_duty = eff_duty_of(duty_i, psc_i);
    wrap_o   = en_i && (phase_o == span - CW'(1));
    pwm_o    = en_i && (DW'(phase_o) < eff_duty);
  end
endmodule

// File: rtl/duty_pwm_top.sv
module duty_pwm_top
  import duty_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pwm_o
);
  logic              en_w;
  logic [PSC_W-1:0]  psc_w;
  logic [DATA_W-1:0] duty_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  phase_w;
  logic              wrap_w;

  duty_pwm_regs #(.AW(ADDR_W), .DW(DATA_W), .PW(PSC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .en_o(en_w), .psc_o(psc_w), .duty_o(duty_w)
  );

  duty_pwm_cnt #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .cnt_o(cnt_w)
  );

  duty_pwm_cmp #(.CW(CNT_W), .PW(PSC_W), .DW(DATA_W)) u_cmp (
    .en_i(en_w), .psc_i(psc_w), .duty_i(duty_w), .cnt_i(cnt_w),
    .phase_o(phase_w), .wrap_o(wrap_w), .pwm_o(pwm_o)
  );

  assert_low_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_w |-> !pwm_o);
  assert_phase_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> phase_w == '0);
  assert_full_duty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && psc_w != '0 && duty_w >= DATA_W'(span_of(psc_w))) |-> pwm_o);
  assert_no_full_at_p0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_w && psc_w == '0) |-> !pwm_o);
  assert_psc_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_w && $past(en_w) && psc_w != $past(psc_w)) |-> cnt_w == CNT_W'($past(cnt_w) + CNT_W'(1)));
endmodule

// File: tb/duty_pwm_top_tb.sv
module duty_pwm_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pwm_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  duty_pwm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
  );

  // bench reference state, built from the requirements
  bit       m_en;
  int       m_psc;
  int       m_duty;
  int       m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en <= 0; m_psc <= 0; m_duty <= 0; m_cnt <= 0;
    end else begin
      m_cnt <= m_en ? (m_cnt + 1) % 256 : 0;
      if (wr_en && addr == 1'b0) begin
        m_en <= wdata[0]; m_psc <= int'(wdata[2:1]);
      end
      if (wr_en && addr == 1'b1) m_duty <= int'(wdata);
    end
  end

  function automatic bit model_pwm();
    int per;
    int lim;
    per = 128 / (1 << m_psc);
    lim = (m_psc == 0 && m_duty > 127) ? 127 : m_duty;
    return m_en && ((m_cnt % per) < lim);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit a, input int d);
    wr_en = 1'b1; addr = a; wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit a, output int d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = int'(rdata);
  endtask

  // step n clocks, comparing the output with the reference every cycle
  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, int'(pwm_o), int'(model_pwm()));
    end
  endtask

  initial begin
    int v;
    int highs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm after reset", int'(pwm_o), 0);
    rd(1'b0, v); check("R1 ctrl after reset", v, 0);
    rd(1'b1, v); check("R1 duty after reset", v, 0);

    // R2 readback; ctrl bits 7:3 read zero
    wr(1'b1, 8'hA5); rd(1'b1, v); check("R2 duty readback", v, 8'hA5);
    wr(1'b0, 8'hF8); rd(1'b0, v); check("R2 ctrl readback upper bits", v, 0);
    wr(1'b0, 8'h06); rd(1'b0, v); check("R2 ctrl readback psc", v, 6);
    check("R3 disabled output low", int'(pwm_o), 0);
    run(10, "R3 disabled hold");

    // R4 R5 R6: sweep of prescaler and duty, high-time per 128 clocks
    for (int p = 0; p < 4; p++) begin
      for (int d = 0; d < 256; d += 3) begin
        int per;
        int lim;
        wr(1'b0, 0);
        wr(1'b1, d);
        wr(1'b0, (p << 1) | 1);
        per = 128 >> p;
        lim = (p == 0) ? ((d > 127) ? 127 : d) : ((d > per) ? per : d);
        highs = 0;
        for (int i = 0; i < 128; i++) begin
          highs += int'(pwm_o);
          check("R5 per-cycle compare", int'(pwm_o), int'(model_pwm()));
          @(negedge clk);
        end
        check((p == 0) ? "R6 high count p0" : "R4 high count", highs, (1 << p) * lim);
      end
    end

    // R6 maximum duty at prescaler 0: last step low
    wr(1'b0, 0); wr(1'b1, 255); wr(1'b0, 1);
    repeat (127) @(negedge clk);
    check("R6 last step low at p0", int'(pwm_o), 0);

    // R3 enable restarts from zero
    wr(1'b0, 0); wr(1'b1, 1); wr(1'b0, 7);
    check("R3 first enabled cycle high (count 0)", int'(pwm_o), 1);
    @(negedge clk);
    check("R3 second cycle low (count 1)", int'(pwm_o), 0);

    // R9 counter wraps through 255
    run(300, "R9 wrap sweep");

    // R7 mid-period duty update
    wr(1'b0, 0); wr(1'b1, 4); wr(1'b0, 7);
    repeat (5) @(negedge clk);
    check("R7 before update phase 5 duty 4", int'(pwm_o), 0);
    wr(1'b1, 12);
    check("R7 phase 6 duty 12 high at once", int'(pwm_o), 1);
    run(40, "R7 after update");

    // R8 prescaler change keeps the counter
    wr(1'b0, 0); wr(1'b1, 5); wr(1'b0, 7);
    repeat (10) @(negedge clk);
    wr(1'b0, 5);
    check("R8 count 11 under p2 low", int'(pwm_o), 0);
    repeat (20) @(negedge clk);
    check("R8 count 31 low", int'(pwm_o), 0);
    @(negedge clk);
    check("R8 count 32 phase 0 high", int'(pwm_o), 1);
    run(100, "R8 after switch");

    // R3 disable mid-run
    wr(1'b0, 4);
    run(20, "R3 disabled again");
    check("R3 output low after disable", int'(pwm_o), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule